// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in a wide unpacked form and turns it into a 32-bit IEEE-754 single-precision word. The unpacked form has a class code, a sign, an unbiased exponent, a normalized significand and a sticky bit. The significand keeps the hidden one, 23 fraction bits, a guard bit, a round bit and a few further low bits. The block rounds the value in one of four modes. It handles the special classes, overflow and gradual underflow, and raises overflow, underflow and inexact flags for each result.

Values arrive on a valid/ready input stream and leave on a valid/ready output stream, through one output register. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when its contents are being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags are held unchanged. The rounding mode and the underflow trap enable are sampled with each input beat.

The input significand `in_mant` has the hidden one at bit 28. Fraction bits sit at 27..5, the guard bit at 4, the round bit at 3, and extra low bits at 2..0. `in_sticky` stands for any nonzero bits below bit 0. For a number, the value is `in_mant / 2^28 * 2^in_exp`.

Top module: `sp_single_packer`

## Requirements
- R1: Class code 3 (NaN) gives exponent field 255, sign kept, and fraction bits 22..0 taken from `in_mant[27:5]`. Fraction bit 22 is forced to 1. No flags are raised.
- R2: Class code 2 (infinity) gives the sign, exponent field 255 and a zero fraction. Class code 0 (zero) gives only the sign bit, with all other bits 0. Neither raises a flag.
- R3: For class code 1 with biased exponent `in_exp+127 >= 1`, the result is rounded to 24 significant bits. Mode 0 rounds to nearest, ties to even. Mode 1 rounds toward zero. Mode 2 rounds toward +inf. Mode 3 rounds toward -inf. Inexact is raised when any discarded bit or the sticky bit is nonzero.
- R4: When rounding a normal carries the significand to 2.0, the exponent field is one higher and the fraction is zero.
- R5: When the final biased exponent is 255 or more, overflow and inexact are both raised. The result is infinity in mode 0, in mode 2 with sign 0, and in mode 3 with sign 1. In every other case it is the largest finite value: exponent 254, fraction all ones.
- R6: A biased exponent of 0 or less takes the subnormal path. The significand, hidden one included, is shifted right by `1 - (in_exp+127)` and then rounded. The result has exponent field 0.
- R7: A subnormal that rounds up to 2^23 becomes the smallest normal: exponent 1, fraction 0. Inexact is raised and underflow is not.
- R8: A result that stays subnormal raises underflow when it is inexact or when `uf_trap_en` is set. Normal results never raise underflow.
- R9: `in_ready` equals `!out_valid || out_ready`. A taken beat appears on the output one cycle later. The output word and flags stay stable while `out_valid && !out_ready`.
- R10: During reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_cls | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_mant | input | 29 | Significand with hidden one at the top |
| in_sticky | input | 1 | OR of bits below `in_mant[0]` |
| rnd_mode | input | 2 | Rounding mode, encoded as in R3 |
| uf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Packed single-precision word |
| out_of | output | 1 | Overflow flag |
| out_uf | output | 1 | Underflow flag |
| out_nx | output | 1 | Inexact flag |

## Verification
Two functions can fall in the same cycle in two places. The first is a round-up carry into the exponent that also crosses into overflow. The bench provokes it with all-ones fractions at exponent 127 in each mode and sign, and expects overflow handling rather than an exponent field of 255 with a zero fraction. The second is a subnormal that rounds up into the smallest normal while the underflow trap is enabled. There the bench expects the promoted word with no underflow flag. The sweep crosses modes, signs, exponents around both boundaries and every combination of the five low bits. The bench compares each result against a model that rounds by comparing twice the integer remainder with the shifted unit.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  localparam int FRAC_W = 23;
  localparam int EBIAS  = 127;
  localparam int EFULL  = 255;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  typedef struct packed {
    logic [31:0] word;
    logic        of;
    logic        uf;
    logic        nx;
  } packed_res_t;
endpackage

// File: rtl/sp_align.sv
// Biases the exponent, picks normal or subnormal path, and splits the
// significand into kept bits, guard, round and sticky.
module sp_align import sp_pack_pkg::*; #(
  parameter  int EXP_W  = 10,
  parameter  int XTRA_W = 3,
  localparam int MANT_W = FRAC_W + 3 + XTRA_W,
  localparam int BE_W   = EXP_W + 1
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  output logic [BE_W-1:0]   bexp_o,
  output logic              subn_o,
  output logic [FRAC_W:0]   keep_o,
  output logic              g_o,
  output logic              r_o,
  output logic              s_o
);
  localparam int SH_W = $clog2(MANT_W + 1);

  logic [BE_W:0]       need;
  logic [SH_W-1:0]     shc;
  logic [2*MANT_W-1:0] ext;
  logic [MANT_W-1:0]   hi;
  logic [MANT_W-1:0]   lo;

  assign bexp_o = {exp_i[EXP_W-1], exp_i} + BE_W'(EBIAS);
  assign subn_o = bexp_o[BE_W-1] | (bexp_o == '0);

  // distance below the smallest normal exponent, capped at a full flush
  assign need = (BE_W+1)'(1) - {bexp_o[BE_W-1], bexp_o};
  assign shc  = !subn_o ? '0 :
                (need > (BE_W+1)'(MANT_W)) ? SH_W'(MANT_W) : need[SH_W-1:0];

  assign ext = {mant_i, {MANT_W{1'b0}}} >> shc;
  assign hi  = ext[2*MANT_W-1 -: MANT_W];
  assign lo  = ext[MANT_W-1:0];

  assign keep_o = hi[MANT_W-1 -: FRAC_W+1];
  assign g_o    = hi[XTRA_W+1];
  assign r_o    = hi[XTRA_W];

  generate
    if (XTRA_W > 0) begin : g_extra
      assign s_o = (|hi[XTRA_W-1:0]) | (|lo) | sticky_i;
    end else begin : g_noextra
      assign s_o = (|lo) | sticky_i;
    end
  endgenerate
endmodule

// File: rtl/sp_rounder.sv
// Decides the round-up increment from mode, sign and guard/round/sticky.
module sp_rounder import sp_pack_pkg::*; (
  input  logic [1:0]        mode_i,
  input  logic              sign_i,
  input  logic [FRAC_W:0]   keep_i,
  input  logic              g_i,
  input  logic              r_i,
  input  logic              s_i,
  output logic [FRAC_W+1:0] sum_o,
  output logic              inexact_o
);
  logic inc;

  assign inexact_o = g_i | r_i | s_i;

  always_comb begin
    unique case (rmode_e'(mode_i))
      RM_NEAR: inc = g_i & (r_i | s_i | keep_i[0]);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = inexact_o & ~sign_i;
      RM_NEG:  inc = inexact_o & sign_i;
      default: inc = 1'b0;
    endcase
  end

  assign sum_o = {1'b0, keep_i} + (FRAC_W+2)'(inc);
endmodule

// File: rtl/sp_assemble.sv
// Builds the packed word and flags for every class and path.
module sp_assemble import sp_pack_pkg::*; #(
  parameter int BE_W = 11
) (
  input  logic [1:0]        cls_i,
  input  logic              sign_i,
  input  logic [BE_W-1:0]   bexp_i,
  input  logic              subn_i,
  input  logic [FRAC_W+1:0] sum_i,
  input  logic              inexact_i,
  input  logic [1:0]        mode_i,
  input  logic              trap_en_i,
  input  logic [FRAC_W-2:0] nan_frac_i,
  output packed_res_t       res_o
);
  logic signed [BE_W:0] be_fin;
  logic                 ovf;
  logic                 to_inf;

  assign be_fin = $signed({bexp_i[BE_W-1], bexp_i}) +
                  $signed({{BE_W{1'b0}}, sum_i[FRAC_W+1]});
  assign ovf    = !subn_i && (be_fin >= $signed((BE_W+1)'(EFULL)));

  always_comb begin
    unique case (rmode_e'(mode_i))
      RM_NEAR: to_inf = 1'b1;
      RM_ZERO: to_inf = 1'b0;
      RM_POS:  to_inf = ~sign_i;
      RM_NEG:  to_inf = sign_i;
      default: to_inf = 1'b1;
    endcase
  end

  always_comb begin
    res_o = '0;
    unique case (cls_e'(cls_i))
      CLS_ZERO: res_o.word = {sign_i, 31'd0};
      CLS_INF:  res_o.word = {sign_i, 8'hFF, 23'd0};
      CLS_NAN:  res_o.word = {sign_i, 8'hFF, 1'b1, nan_frac_i};
      default: begin
        res_o.nx = inexact_i;
        if (subn_i) begin
          if (sum_i[FRAC_W]) begin
            res_o.word = {sign_i, 8'd1, 23'd0};
          end else begin
            res_o.word = {sign_i, 8'd0, sum_i[FRAC_W-1:0]};
            res_o.uf   = inexact_i | trap_en_i;
          end
        end else if (ovf) begin
          res_o.of   = 1'b1;
          res_o.nx   = 1'b1;
          res_o.word = to_inf ? {sign_i, 8'hFF, 23'd0}
                              : {sign_i, 8'hFE, {FRAC_W{1'b1}}};
        end else begin
          res_o.word = {sign_i, be_fin[7:0], sum_i[FRAC_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/sp_single_packer.sv
module sp_single_packer import sp_pack_pkg::*; #(
  parameter  int EXP_W  = 10,
  parameter  int XTRA_W = 3,
  localparam int MANT_W = FRAC_W + 3 + XTRA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  input  logic              uf_trap_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_word,
  output logic              out_of,
  output logic              out_uf,
  output logic              out_nx
);
  localparam int BE_W = EXP_W + 1;

  logic [BE_W-1:0]   bexp;
  logic              subn;
  logic [FRAC_W:0]   keep;
  logic              g, r, s;
  logic [FRAC_W+1:0] sum;
  logic              inexact;
  packed_res_t       res;
  logic              fire;

  sp_align #(.EXP_W(EXP_W), .XTRA_W(XTRA_W)) u_align (
    .exp_i(in_exp), .mant_i(in_mant), .sticky_i(in_sticky),
    .bexp_o(bexp), .subn_o(subn), .keep_o(keep),
    .g_o(g), .r_o(r), .s_o(s)
  );

  sp_rounder u_round (
    .mode_i(rnd_mode), .sign_i(in_sign), .keep_i(keep),
    .g_i(g), .r_i(r), .s_i(s), .sum_o(sum), .inexact_o(inexact)
  );

  sp_assemble #(.BE_W(BE_W)) u_asm (
    .cls_i(in_cls), .sign_i(in_sign), .bexp_i(bexp), .subn_i(subn),
    .sum_i(sum), .inexact_i(inexact), .mode_i(rnd_mode),
    .trap_en_i(uf_trap_en), .nan_frac_i(in_mant[MANT_W-3 -: FRAC_W-1]),
    .res_o(res)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_of    <= 1'b0;
      out_uf    <= 1'b0;
      out_nx    <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_word  <= res.word;
        out_of    <= res.of;
        out_uf    <= res.uf;
        out_nx    <= res.nx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: a taken NaN beat shows exponent 255 with the quiet bit set
  a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_cls == CLS_NAN) |=> (out_valid && out_word[30:22] == 9'h1FF));

  // R2: a taken infinity beat shows exponent 255, zero fraction, no flags
  a_r2_inf_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_cls == CLS_INF) |=>
      (out_word[30:0] == {8'hFF, 23'd0} && !out_of && !out_uf && !out_nx));

  // R5: overflow always comes with inexact and a top-range exponent
  a_r5_of_with_nx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_of) |-> (out_nx && out_word[30:23] >= 8'hFE));

  // R8: underflow only ever accompanies a subnormal encoding
  a_r8_uf_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uf) |-> (out_word[30:23] == 8'd0 && !out_of));

  // R9: a stalled result holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_word) && $stable(out_of) &&
       $stable(out_uf) && $stable(out_nx)));
endmodule

// File: tb/tb_sp_single_packer.sv
module tb_sp_single_packer;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_cls = '0;
  logic          in_sign = 1'b0;
  logic [9:0]    in_exp = '0;
  logic [MW-1:0] in_mant = '0;
  logic          in_sticky = 1'b0;
  logic [1:0]    rnd_mode = '0;
  logic          uf_trap_en = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_word;
  logic          out_of, out_uf, out_nx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_single_packer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_of(out_of), .out_uf(out_uf), .out_nx(out_nx)
  );

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act={of,uf,nx,word}=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference: integer remainder against the shifted unit
  task automatic model(input logic [1:0] cls, input logic sg, input int ex,
                       input logic [MW-1:0] m, input logic st, input logic [1:0] md,
                       input logic te, output logic [34:0] res, output string tag);
    longint unsigned q, rem, full, two_rem;
    int be, sh;
    logic nx, up;
    logic [31:0] w;
    res = '0;
    tag = "R3";
    if (cls == 2'd0) begin res = {3'b000, sg, 31'd0}; tag = "R2"; return; end
    if (cls == 2'd2) begin res = {3'b000, sg, 8'hFF, 23'd0}; tag = "R2"; return; end
    if (cls == 2'd3) begin
      res = {3'b000, sg, 8'hFF, 1'b1, m[26:5]}; tag = "R1"; return;
    end
    be = ex + 127;
    sh = (be >= 1) ? 5 : 5 + 1 - be;
    if (sh > 40) sh = 40;
    q = longint'(m) >> sh;
    rem = longint'(m) - (q << sh);
    full = 64'd1 << sh;
    two_rem = 2 * rem + longint'(st);
    nx = (two_rem != 0);
    case (md)
      2'd0: up = (two_rem > full) || (two_rem == full && q[0]);
      2'd1: up = 1'b0;
      2'd2: up = nx && !sg;
      default: up = nx && sg;
    endcase
    q = q + longint'(up);
    if (be >= 1) begin
      if (q == (64'd1 << 24)) begin be++; q = 64'd1 << 23; tag = "R4"; end
      if (be >= 255) begin
        tag = "R5";
        if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg))
          w = {sg, 8'hFF, 23'd0};
        else
          w = {sg, 8'hFE, 23'h7FFFFF};
        res = {3'b101, w};
      end else begin
        res = {1'b0, 1'b0, nx, sg, be[7:0], q[22:0]};
      end
    end else if (q == (64'd1 << 23)) begin
      tag = "R7";
      res = {3'b001, sg, 8'd1, 23'd0};
    end else begin
      tag = (nx || te) ? "R8" : "R6";
      res = {1'b0, nx || te, nx, sg, 8'd0, q[22:0]};
    end
  endtask

  task automatic xfer(input logic [1:0] cls, input logic sg, input int ex,
                      input logic [MW-1:0] m, input logic st, input logic [1:0] md,
                      input logic te);
    logic [34:0] exp_res;
    string tag;
    @(negedge clk);
    in_cls = cls; in_sign = sg; in_exp = 10'(ex); in_mant = m;
    in_sticky = st; rnd_mode = md; uf_trap_en = te; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(cls, sg, ex, m, st, md, te, exp_res, tag);
    if (!out_valid) begin
      checks++; fails++;
      $display("FAIL %s out_valid act=0 exp=1", tag);
    end
    chk(tag, {out_of, out_uf, out_nx, out_word}, exp_res);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [MW-1:0] tops [3];
    tops[0] = 29'h1000_0000;
    tops[1] = 29'h1FFF_FFE0;
    tops[2] = 29'h1000_0020;

    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10 reset out_valid", {34'd0, out_valid}, 35'd0);
    chk("R10 reset in_ready", {34'd0, in_ready}, 35'd1);
    rst_n = 1'b1;

    // R1: NaN with quiet bit clear and set in the input
    xfer(2'd3, 1'b0, 0, 29'h1055_5555, 1'b0, 2'd0, 1'b0);
    xfer(2'd3, 1'b1, 5, 29'h1AB3_C0DF, 1'b1, 2'd3, 1'b1);
    // R2: infinity and zero of both signs
    xfer(2'd2, 1'b1, 0, 29'h1FFF_FFFF, 1'b1, 2'd1, 1'b1);
    xfer(2'd2, 1'b0, 0, 29'h0, 1'b0, 2'd0, 1'b0);
    xfer(2'd0, 1'b1, 0, 29'h1234_5678, 1'b1, 2'd2, 1'b1);
    xfer(2'd0, 1'b0, 0, 29'h0, 1'b0, 2'd0, 1'b0);

    // R3..R8: sweep over mode, sign, exponent, significand and low bits
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int ei = 0; ei < 35; ei++)
          for (int ti = 0; ti < 3; ti++)
            for (int lo = 0; lo < 32; lo++)
              for (int st = 0; st < 2; st++) begin
                int ex;
                ex = (ei < 28) ? -151 + ei : (ei < 32) ? 97 + ei :
                     (ei == 32) ? 0 : (ei == 33) ? -400 : 400;
                xfer(2'd1, sg[0], ex, tops[ti] | 29'(lo), st[0], md[1:0],
                     lo[1] ^ st[0]);
              end

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_cls = 2'd1; in_sign = 1'b0; in_exp = 10'd0; in_mant = 29'h1000_0000;
    in_sticky = 1'b0; rnd_mode = 2'd0; uf_trap_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 ready low when full and stalled", {34'd0, in_ready}, 35'd0);
    in_cls = 2'd2; in_sign = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 stalled word held", {3'b000, out_word}, {3'b000, 32'h3F80_0000});
    chk("R9 stalled valid held", {34'd0, out_valid}, 35'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next beat after release", {out_valid, 2'b00, out_word}, {1'b1, 2'b00, 32'hFF80_0000});
    @(negedge clk);
    chk("R9 drained", {34'd0, out_valid}, 35'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule